// File: doc/BRIEF.md
# Lane-Group Scan and Reduction Sequencer

This block holds one 32-bit integer for each of 32 lanes and turns them into per-lane results through a fixed series of exchange-and-add steps. One operation code selects the result. A forward inclusive prefix sum leaves in each lane the total of itself and every lower lane. A reverse inclusive prefix sum leaves in each lane the total of itself and every higher lane. A full reduction leaves the sum of all 32 inputs in every lane.

A one-cycle start pulse, taken while the engine is idle, captures the operation code and all lane inputs. The engine then runs five steps, one per clock. Each step moves values between lanes under one of three exchange rules:

- shift toward higher lanes;
- shift toward lower lanes;
- swap by XOR of the lane index.

Each rule has a fixed clamp that marks where a source lane is valid. Prefix scans use offsets that double from 1 to 16. In a scan step, a lane adds what it receives only when its source lane was valid. The reduction uses XOR offsets that halve from 16 down to 1 and adds on every step.

A one-cycle done pulse marks the point where the results are ready. They then stay on the output until the next accepted start.

Top module: `lane_scan_seq`

## Requirements
- R1: While reset is held, and after it is released, busy_o and done_o are 0 and every lane of lanes_o is 0 until the first accepted start.
- R2: Operation code 0 gives a forward inclusive scan. Lane k of lanes_o (bits 32k+31:32k) equals the sum of input lanes 0 to k.
- R3: Operation code 1 gives a reverse inclusive scan. Lane k equals the sum of input lanes k to 31.
- R4: Operation codes 2 and 3 both give a reduction, in which every lane equals the sum of all 32 input lanes.
- R5: All sums are 32-bit two's-complement and wrap modulo 2^32.
- R6: A start is accepted at a rising edge while busy_o is 0. busy_o is then 1 for exactly five cycles. done_o is 1 for exactly one cycle, the cycle right after those five, with busy_o at 0.
- R7: A start pulse while busy_o is 1 has no effect. The running operation keeps its operation code, its captured inputs and its completion time.
- R8: While busy_o is 0 and no start is given, lanes_o holds its value whatever lanes_i and op_i do.
- R9: In a forward scan, lane 0 returns its own input unchanged. In a reverse scan, lane 31 returns its own input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; takes effect only while idle |
| op_i | input | 2 | Operation: 0 forward scan, 1 reverse scan, 2 or 3 reduction |
| lanes_i | input | 1024 | Lane inputs; lane k in bits 32k+31:32k |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when results are ready |
| lanes_o | output | 1024 | Per-lane results, same packing as lanes_i |

## Verification
A wrong step counter or a wrong offset schedule shows up at the ports on the very operation that exposes it. The done pulse arrives early or late, or lanes near the scan boundaries pick up missing or doubled terms. Errors in gating or in the clamp corrupt only the lanes whose source falls outside the valid range, so they appear in the low lanes of a forward scan or the high lanes of a reverse scan. A lane register that loads or steps when it should not breaks the hold of lanes_o in the idle cycles after done. It can also let a start that arrives mid-run replace the captured inputs, which then shows at the next done.

// File: rtl/lane_scan_pkg.sv
package lane_scan_pkg;

  typedef enum logic [1:0] {
    OP_SCAN_FWD   = 2'd0,
    OP_SCAN_REV   = 2'd1,
    OP_REDUCE     = 2'd2,
    OP_REDUCE_ALT = 2'd3
  } scan_op_e;

  typedef enum logic [1:0] {
    XCH_UP   = 2'd0,
    XCH_DOWN = 2'd1,
    XCH_XOR  = 2'd2
  } xchg_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_e;

endpackage

// File: rtl/lane_scan_ctrl.sv
module lane_scan_ctrl
  import lane_scan_pkg::*;
#(
  parameter int LANES = 32,
  localparam int IDX = $clog2(LANES),
  localparam int SW  = $clog2(IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  output logic             load_o,
  output logic             step_en_o,
  output xchg_mode_e       mode_o,
  output logic [IDX-1:0]   offset_o,
  output logic [IDX-1:0]   clamp_o,
  output logic             gate_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [SW-1:0]  LAST_STEP = SW'(IDX - 1);
  localparam logic [IDX-1:0] ONE       = IDX'(1);

  ctrl_state_e    state_q, state_d;
  logic [SW-1:0]  step_q, step_d;
  xchg_mode_e     mode_q, mode_d;
  logic           gate_q, gate_d;
  logic           done_q, done_d;
  logic [SW-1:0]  shamt;

  // next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    mode_d  = mode_q;
    gate_d  = gate_q;
    done_d  = 1'b0;
    load_o    = 1'b0;
    step_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_RUN;
          step_d  = '0;
          unique case (scan_op_e'(op_i))
            OP_SCAN_FWD: begin mode_d = XCH_UP;   gate_d = 1'b1; end
            OP_SCAN_REV: begin mode_d = XCH_DOWN; gate_d = 1'b1; end
            default:     begin mode_d = XCH_XOR;  gate_d = 1'b0; end
          endcase
        end
      end
      ST_RUN: begin
        step_en_o = 1'b1;
        step_d    = step_q + SW'(1);
        if (step_q == LAST_STEP) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      mode_q  <= XCH_UP;
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      mode_q  <= mode_d;
      gate_q  <= gate_d;
      done_q  <= done_d;
    end
  end

  // offsets double for the scans and halve for the butterfly
  assign shamt    = (mode_q == XCH_XOR) ? (LAST_STEP - step_q) : step_q;
  assign offset_o = ONE << shamt;
  // clamp: 0 for the shift-up rule, the top lane index otherwise
  assign clamp_o  = (mode_q == XCH_UP) ? '0 : '1;
  assign mode_o   = mode_q;
  assign gate_o   = gate_q;
  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;

endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
  import lane_scan_pkg::*;
#(
  parameter int LANES = 32,
  parameter int WIDTH = 32,
  localparam int IDX = $clog2(LANES)
) (
  input  xchg_mode_e                   mode_i,
  input  logic [IDX-1:0]               offset_i,
  input  logic [IDX-1:0]               clamp_i,
  input  logic [LANES-1:0][WIDTH-1:0]  vals_i,
  output logic [LANES-1:0][WIDTH-1:0]  recv_o,
  output logic [LANES-1:0]             valid_o
);

  localparam int JW = IDX + 2;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic signed [JW-1:0] self_s, off_s, lim_s, j_s;
      logic                 ok;
      logic [IDX-1:0]       src;

      always_comb begin
        self_s = $signed(JW'(k));
        off_s  = $signed({2'b00, offset_i});
        lim_s  = $signed({2'b00, clamp_i});
        unique case (mode_i)
          XCH_UP: begin
            j_s = self_s - off_s;
            ok  = (j_s >= lim_s);
          end
          XCH_DOWN: begin
            j_s = self_s + off_s;
            ok  = (j_s <= lim_s);
          end
          default: begin
            j_s = self_s ^ off_s;
            ok  = (j_s <= lim_s);
          end
        endcase
        src = ok ? j_s[IDX-1:0] : IDX'(k);
      end

      assign recv_o[k]  = vals_i[src];
      assign valid_o[k] = ok;
    end
  endgenerate

endmodule

// File: rtl/lane_accum.sv
module lane_accum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] own_i,
  input  logic [WIDTH-1:0] recv_i,
  input  logic             valid_i,
  input  logic             gate_i,
  output logic [WIDTH-1:0] sum_o
);

  // gated steps keep the own value when the source was out of range
  assign sum_o = (gate_i && !valid_i) ? own_i : (own_i + recv_i);

endmodule

// File: rtl/lane_scan_seq.sv
module lane_scan_seq
  import lane_scan_pkg::*;
#(
  parameter int LANES = 32,
  parameter int WIDTH = 32,
  localparam int IDX = $clog2(LANES),
  localparam int BUSW = LANES * WIDTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [BUSW-1:0] lanes_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [BUSW-1:0] lanes_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  logic            load, step_en, gate;
  xchg_mode_e      mode;
  logic [IDX-1:0]  offset, clamp;

  lane_scan_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start_i   (start_i),
    .op_i      (op_i),
    .load_o    (load),
    .step_en_o (step_en),
    .mode_o    (mode),
    .offset_o  (offset),
    .clamp_o   (clamp),
    .gate_o    (gate),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  logic [LANES-1:0][WIDTH-1:0] val_q, val_d, recv, sum;
  logic [LANES-1:0]            valid;
  logic                        val_en;

  lane_shuffle #(.LANES(LANES), .WIDTH(WIDTH)) u_shuffle (
    .mode_i   (mode),
    .offset_i (offset),
    .clamp_i  (clamp),
    .vals_i   (val_q),
    .recv_o   (recv),
    .valid_o  (valid)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_acc
      lane_accum #(.WIDTH(WIDTH)) u_acc (
        .own_i   (val_q[k]),
        .recv_i  (recv[k]),
        .valid_i (valid[k]),
        .gate_i  (gate),
        .sum_o   (sum[k])
      );
    end
  endgenerate

  // next-state for the lane registers
  assign val_en = load | step_en;
  always_comb begin
    if (load) val_d = lanes_i;
    else      val_d = sum;
  end

  // lane registers with explicit enable
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  val_q <= '0;
    else if (val_en)  val_q <= val_d;
  end

  assign lanes_o = val_q;

endmodule

// File: rtl/lane_scan_chk.sv
module lane_scan_chk #(
  parameter int LANES = 32,
  parameter int WIDTH = 32,
  localparam int BUSW = LANES * WIDTH,
  localparam int STEPS = $clog2(LANES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [1:0]      op_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [BUSW-1:0] lanes_o
);

  logic [7:0] cnt_q;
  logic       red_q;
  logic       accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      red_q <= 1'b0;
    end else begin
      if (accept) begin
        cnt_q <= '0;
        red_q <= op_i[1];
      end else if (busy_o && cnt_q != 8'hff) begin
        cnt_q <= cnt_q + 8'd1;
      end
    end
  end

  function automatic logic all_same(input logic [BUSW-1:0] v);
    logic r;
    r = 1'b1;
    for (int k = 1; k < LANES; k++)
      if (v[k*WIDTH +: WIDTH] != v[WIDTH-1:0]) r = 1'b0;
    return r;
  endfunction

  a_r6_done_after_steps: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && cnt_q == 8'(STEPS)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < 8'(STEPS)));

  a_r7_busy_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt_q < 8'(STEPS - 1)) |=> (busy_o && !done_o));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(lanes_o));

  a_r4_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && red_q) |-> all_same(lanes_o));

endmodule

bind lane_scan_seq lane_scan_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .start_i (start_i),
  .op_i    (op_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .lanes_o (lanes_o)
);

// File: tb/lane_scan_seq_test.sv
`timescale 1ns/1ps
module lane_scan_seq_test;

  localparam int LANES = 32;
  localparam int WIDTH = 32;
  localparam int BUSW  = LANES * WIDTH;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [1:0]      op_i;
  logic [BUSW-1:0] lanes_i;
  logic            busy_o, done_o;
  logic [BUSW-1:0] lanes_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [WIDTH-1:0] a   [LANES];
  logic [WIDTH-1:0] exp_v [LANES];

  always #10 clk = ~clk;

  lane_scan_seq #(.LANES(LANES), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .lanes_i(lanes_i), .busy_o(busy_o), .done_o(done_o), .lanes_o(lanes_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [BUSW-1:0] rand_bus();
    logic [BUSW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*WIDTH +: WIDTH] = $urandom;
    return v;
  endfunction

  // expected values from the requirements
  task automatic compute_expected(input logic [1:0] op);
    logic [WIDTH-1:0] acc;
    if (op == 2'd0) begin
      acc = '0;
      for (int k = 0; k < LANES; k++) begin acc = acc + a[k]; exp_v[k] = acc; end
    end else if (op == 2'd1) begin
      acc = '0;
      for (int k = LANES - 1; k >= 0; k--) begin acc = acc + a[k]; exp_v[k] = acc; end
    end else begin
      acc = '0;
      for (int k = 0; k < LANES; k++) acc = acc + a[k];
      for (int k = 0; k < LANES; k++) exp_v[k] = acc;
    end
  endtask

  // runs one operation; optional start pulse in the middle of the run
  task automatic run_op(input logic [1:0] op, input string req, input bit inject);
    int lane_bad;
    logic tim_ok;
    compute_expected(op);
    @(negedge clk);
    for (int k = 0; k < LANES; k++) lanes_i[k*WIDTH +: WIDTH] = a[k];
    op_i    = op;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lanes_i = rand_bus();
    op_i    = 2'($urandom);
    tim_ok  = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      if (done_o !== (c == 6) || busy_o !== (c < 6)) tim_ok = 1'b0;
      if (inject && c == 3) begin
        start_i = 1'b1;
        op_i    = op + 2'd1;
        lanes_i = rand_bus();
      end
      if (inject && c == 4) start_i = 1'b0;
      if (c < 6) @(negedge clk);
    end
    // R6: busy for five cycles, done in the sixth
    check("R6", "busy/done timing", {63'd0, tim_ok}, 64'd1);
    lane_bad = 0;
    for (int k = 0; k < LANES; k++)
      if (lanes_o[k*WIDTH +: WIDTH] !== exp_v[k]) begin
        if (lane_bad == 0)
          check(req, $sformatf("lane %0d op %0d", k, op),
                {32'd0, lanes_o[k*WIDTH +: WIDTH]}, {32'd0, exp_v[k]});
        lane_bad++;
      end
    if (lane_bad == 0) check(req, "all lanes", 64'd0, 64'd0);
    @(negedge clk);
    // R6: done lasts one cycle
    check("R6", "done pulse width", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
  end

  initial begin
    logic [BUSW-1:0] snap;
    rst_n   = 1'b0;
    start_i = 1'b0;
    op_i    = 2'd0;
    lanes_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy in reset", {63'd0, busy_o}, 64'd0);
    check("R1", "done in reset", {63'd0, done_o}, 64'd0);
    check("R1", "lanes in reset", {63'd0, |lanes_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "lanes after release", {63'd0, |lanes_o}, 64'd0);

    // index pattern, all three operations
    for (int k = 0; k < LANES; k++) a[k] = WIDTH'(k + 1);
    run_op(2'd0, "R2", 1'b0);
    // R9: forward scan lane 0 is its own input
    check("R9", "fwd lane 0", {32'd0, lanes_o[WIDTH-1:0]}, {32'd0, a[0]});
    run_op(2'd1, "R3", 1'b0);
    // R9: reverse scan lane 31 is its own input
    check("R9", "rev lane 31", {32'd0, lanes_o[(LANES-1)*WIDTH +: WIDTH]}, {32'd0, a[LANES-1]});
    run_op(2'd2, "R4", 1'b0);
    check("R4", "index total", {32'd0, lanes_o[WIDTH-1:0]}, 64'd528);

    // single-lane impulses walk through every lane position
    for (int p = 0; p < LANES; p++) begin
      for (int k = 0; k < LANES; k++) a[k] = (k == p) ? WIDTH'(p + 7) : '0;
      run_op(2'(p % 3), (p % 3 == 0) ? "R2" : (p % 3 == 1) ? "R3" : "R4", 1'b0);
    end

    // random patterns
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < LANES; k++) a[k] = $urandom;
      run_op(2'd0, "R2", 1'b0);
      run_op(2'd1, "R3", 1'b0);
      run_op(2'd2, "R4", 1'b0);
      run_op(2'd3, "R4", 1'b0);
    end

    // R5: all ones wrap modulo 2^32
    for (int k = 0; k < LANES; k++) a[k] = '1;
    run_op(2'd2, "R5", 1'b0);
    check("R5", "wrapped total", {32'd0, lanes_o[WIDTH-1:0]}, 64'h0000_0000_FFFF_FFE0);
    run_op(2'd0, "R5", 1'b0);
    for (int k = 0; k < LANES; k++) a[k] = 32'h8000_0000 + WIDTH'(k);
    run_op(2'd1, "R5", 1'b0);

    // R7: start during a run is ignored
    for (int k = 0; k < LANES; k++) a[k] = $urandom;
    run_op(2'd0, "R7", 1'b1);
    run_op(2'd2, "R7", 1'b1);

    // R8: idle outputs hold while inputs move
    snap = lanes_o;
    for (int c = 0; c < 5; c++) begin
      lanes_i = rand_bus();
      op_i    = 2'($urandom);
      @(negedge clk);
    end
    check("R8", "idle hold", {63'd0, lanes_o !== snap}, 64'd0);
    check("R8", "idle busy", {63'd0, busy_o}, 64'd0);

    summary();
  end

endmodule